// File: doc/BRIEF.md
# DMA Channel Request Front End

This block sits in front of the channel arbiter of a DMA controller, one instance per channel. It picks one of eight peripheral request lines with a 3-bit select field. A rising edge on that line counts as one hardware request, and it is accepted only while the channel's hardware-request enable is set. A software request strobe is merged with it. Any accepted request sets the pending flag `pend_o`, which is the channel's request to the arbiter.

The pending flag is cleared by software or by the completion strobes from the channel engine. One configuration bit decides whether it is dropped after every transfer or only after the whole transaction. A request that arrives while the flag is already set cannot be stored, so the block sets a sticky lost-request flag and pulses an interrupt. In single mode the end of a transaction also turns off hardware requests. In continuous mode they stay enabled. A suspend request is formed from the channel's suspend enable and the global suspend condition.

Top module: `dma_req_front`

## Requirements
- R1: `sel_i` chooses which bit of `hw_req_i` is watched (value k selects bit k). A 0-to-1 transition on that bit, seen while `hen_o` is 1, sets `pend_o` on the next clock edge. Transitions on the other bits, and a line that is held high, set nothing.
- R2: While `hen_o` is 0, rising edges on the selected line do not set `pend_o`.
- R3: `hen_set_i` sets `hen_o` and `hen_clr_i` clears it, both on the next edge. When both are high together, the set wins.
- R4: When `single_i`=1, `txn_done_i` clears `hen_o` (unless `hen_set_i` is high in the same cycle). When `single_i`=0, `txn_done_i` leaves `hen_o` unchanged.
- R5: `sw_req_i` sets `pend_o` on the next edge, whatever the value of `hen_o`.
- R6: When `clr_txn_i`=0, `xfer_done_i` clears `pend_o`, and `txn_done_i` on its own does not.
- R7: When `clr_txn_i`=1, `txn_done_i` clears `pend_o`, and `xfer_done_i` on its own does not.
- R8: `pend_clr_i` clears `pend_o` on the next edge.
- R9: If a request and a clear of `pend_o` happen in the same cycle, `pend_o` stays 1 and the request is not counted as lost.
- R10: A request that arrives while `pend_o`=1 and no clear is active sets `lost_o` on the next edge. At the same edge `lost_irq_o` goes high for exactly one cycle.
- R11: `lost_o` stays set until `lost_clr_i` is high. A new lost request in the same cycle as `lost_clr_i` keeps `lost_o` set.
- R12: `susp_req_o` is high exactly when both `susp_en_i` and `susp_glob_i` are high. It is combinational, with no clock delay.
- R13: While `rst_n` is low, `pend_o`, `hen_o`, `lost_o` and `lost_irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req_i | input | 8 | Peripheral request lines |
| sel_i | input | 3 | Index of the request line to watch |
| single_i | input | 1 | 1 = single mode, 0 = continuous mode |
| clr_txn_i | input | 1 | 1 = clear pending at transaction end, 0 = at transfer end |
| sw_req_i | input | 1 | Software request strobe |
| hen_set_i | input | 1 | Software set of the hardware-request enable |
| hen_clr_i | input | 1 | Software clear of the hardware-request enable |
| pend_clr_i | input | 1 | Software clear of the pending flag |
| lost_clr_i | input | 1 | Write-one-to-clear of the lost-request flag |
| xfer_done_i | input | 1 | End-of-transfer strobe from the channel engine |
| txn_done_i | input | 1 | End-of-transaction strobe from the channel engine |
| susp_en_i | input | 1 | Channel suspend enable |
| susp_glob_i | input | 1 | Global suspend condition |
| pend_o | output | 1 | Pending request to the channel arbiter |
| hen_o | output | 1 | Hardware-request enable state |
| lost_o | output | 1 | Sticky lost-request error flag |
| lost_irq_o | output | 1 | One-cycle lost-request interrupt pulse |
| susp_req_o | output | 1 | Suspend request |

## Verification
Every registered result (`pend_o`, `hen_o`, `lost_o`, `lost_irq_o`) is due at the first rising edge after the strobe or line edge that causes it. `susp_req_o` follows its inputs within the same cycle. The bench drives all inputs on the falling edge and samples the registered outputs at the next falling edge, after exactly one rising edge has passed. It checks the suspend output a nanosecond after driving it. The interrupt is sampled a second time one cycle later to confirm it lasts only one cycle. The select sweep covers all 64 pairs of selected line and pulsed line, both with the enable on and with it off.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int unsigned REQ_LINES = 8;

  typedef enum logic { HEN_CONTINUOUS = 1'b0, HEN_SINGLE = 1'b1 } hen_mode_e;
  typedef enum logic { CLR_PER_XFER = 1'b0, CLR_PER_TXN = 1'b1 } clr_pol_e;
endpackage

// File: rtl/req_line_sel.sv
module req_line_sel #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 edge_o
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] prev_d;
  logic [NUM_LINES-1:0] rise;

  // one edge detector per line, so a change of select never fakes an edge
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_edge
    assign rise[g] = lines_i[g] & ~prev_q[g];
  end

  always_comb begin
    prev_d = lines_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign edge_o = rise[sel_i];
endmodule

// File: rtl/req_hw_enable.sv
module req_hw_enable
  import dma_req_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hen_mode_e mode_i,
  input  logic      set_i,
  input  logic      clr_i,
  input  logic      txn_done_i,
  output logic      hen_o
);
  logic hen_q, hen_d, auto_clr;

  always_comb begin
    auto_clr = (mode_i == HEN_SINGLE) && txn_done_i;
    hen_d    = hen_q;
    if (clr_i || auto_clr) hen_d = 1'b0;
    if (set_i)             hen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hen_q <= 1'b0;
    else        hen_q <= hen_d;
  end

  assign hen_o = hen_q;

  // R3
  hen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> hen_q);
  // R4
  hen_single_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == HEN_SINGLE && txn_done_i && !set_i) |=> !hen_q);
  // R4
  hen_cont_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == HEN_CONTINUOUS && hen_q && !clr_i) |=> hen_q);
endmodule

// File: rtl/req_pending.sv
module req_pending
  import dma_req_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hw_ev_i,
  input  logic     sw_req_i,
  input  clr_pol_e pol_i,
  input  logic     xfer_done_i,
  input  logic     txn_done_i,
  input  logic     pend_clr_i,
  input  logic     lost_clr_i,
  output logic     pend_o,
  output logic     lost_o,
  output logic     irq_o
);
  logic pend_q, pend_d;
  logic lost_q, lost_d;
  logic irq_q, irq_d;
  logic set_ev, clr_ev, lost_ev;

  always_comb begin
    set_ev  = hw_ev_i | sw_req_i;
    clr_ev  = pend_clr_i |
              ((pol_i == CLR_PER_XFER) & xfer_done_i) |
              ((pol_i == CLR_PER_TXN)  & txn_done_i);
    lost_ev = set_ev & pend_q & ~clr_ev;
    pend_d  = set_ev | (pend_q & ~clr_ev);
    lost_d  = lost_ev | (lost_q & ~lost_clr_i);
    irq_d   = lost_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lost_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      lost_q <= lost_d;
      irq_q  <= irq_d;
    end
  end

  assign pend_o = pend_q;
  assign lost_o = lost_q;
  assign irq_o  = irq_q;

  // R5
  sw_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req_i |=> pend_q);
  // R8
  sw_clr_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr_i && !sw_req_i && !hw_ev_i) |=> !pend_q);
  // R7
  txn_pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_i == CLR_PER_TXN && pend_q && !txn_done_i && !pend_clr_i) |=> pend_q);
  // R10
  lost_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req_i && pend_q && !pend_clr_i && !xfer_done_i && !txn_done_i) |=> (lost_q && irq_q));
  // R9
  no_lost_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr_i && !lost_q) |=> !irq_q);
  // R11
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q && !lost_clr_i) |=> lost_q);
  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> lost_q);
endmodule

// File: rtl/dma_req_front.sv
module dma_req_front
  import dma_req_pkg::*;
#(
  parameter int unsigned NUM_LINES = REQ_LINES,
  localparam int unsigned SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] hw_req_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 single_i,
  input  logic                 clr_txn_i,
  input  logic                 sw_req_i,
  input  logic                 hen_set_i,
  input  logic                 hen_clr_i,
  input  logic                 pend_clr_i,
  input  logic                 lost_clr_i,
  input  logic                 xfer_done_i,
  input  logic                 txn_done_i,
  input  logic                 susp_en_i,
  input  logic                 susp_glob_i,
  output logic                 pend_o,
  output logic                 hen_o,
  output logic                 lost_o,
  output logic                 lost_irq_o,
  output logic                 susp_req_o
);
  logic      line_edge;
  logic      hw_ev;
  logic      hen;
  hen_mode_e mode;
  clr_pol_e  pol;

  assign mode = single_i  ? HEN_SINGLE  : HEN_CONTINUOUS;
  assign pol  = clr_txn_i ? CLR_PER_TXN : CLR_PER_XFER;

  req_line_sel #(.NUM_LINES(NUM_LINES)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_i (hw_req_i),
    .sel_i   (sel_i),
    .edge_o  (line_edge)
  );

  req_hw_enable u_hen (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .set_i      (hen_set_i),
    .clr_i      (hen_clr_i),
    .txn_done_i (txn_done_i),
    .hen_o      (hen)
  );

  assign hw_ev = line_edge & hen;

  req_pending u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_ev_i     (hw_ev),
    .sw_req_i    (sw_req_i),
    .pol_i       (pol),
    .xfer_done_i (xfer_done_i),
    .txn_done_i  (txn_done_i),
    .pend_clr_i  (pend_clr_i),
    .lost_clr_i  (lost_clr_i),
    .pend_o      (pend_o),
    .lost_o      (lost_o),
    .irq_o       (lost_irq_o)
  );

  assign hen_o      = hen;
  assign susp_req_o = susp_en_i & susp_glob_i;

  // R2
  gated_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hen_o && !sw_req_i && !pend_o) |=> !pend_o);
endmodule

// File: tb/sim_dma_req_front.sv
`timescale 1ns/1ps
module sim_dma_req_front;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] hw_req_i;
  logic [2:0] sel_i;
  logic single_i, clr_txn_i, sw_req_i, hen_set_i, hen_clr_i, pend_clr_i;
  logic lost_clr_i, xfer_done_i, txn_done_i, susp_en_i, susp_glob_i;
  logic pend_o, hen_o, lost_o, lost_irq_o, susp_req_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dma_req_front u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b, expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet();
    sw_req_i = 0; hen_set_i = 0; hen_clr_i = 0; pend_clr_i = 0;
    lost_clr_i = 0; xfer_done_i = 0; txn_done_i = 0; hw_req_i = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    quiet();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; quiet(); sel_i = 0; single_i = 0; clr_txn_i = 0;
    susp_en_i = 0; susp_glob_i = 0;
    sw_req_i = 1; hen_set_i = 1;
    repeat (3) @(negedge clk);
    // R13
    chk("R13 pend", pend_o, 0); chk("R13 hen", hen_o, 0);
    chk("R13 lost", lost_o, 0); chk("R13 irq", lost_irq_o, 0);
    quiet();
    rst_n = 1;
    @(negedge clk);

    // R3 software control of enable
    hen_set_i = 1; tick(); chk("R3 set", hen_o, 1);
    hen_clr_i = 1; tick(); chk("R3 clr", hen_o, 0);
    hen_set_i = 1; hen_clr_i = 1; tick(); chk("R3 set wins", hen_o, 1);

    // R1 / R2 sweep over enable, select and pulsed line
    for (int en = 0; en < 2; en++) begin
      for (int s = 0; s < 8; s++) begin
        for (int l = 0; l < 8; l++) begin
          if (en == 1) hen_set_i = 1; else hen_clr_i = 1;
          tick();
          sel_i = 3'(s); hw_req_i[l] = 1'b1;
          tick();
          if (en == 1) chk("R1 select", pend_o, (l == s));
          else         chk("R2 gated", pend_o, 0);
          pend_clr_i = 1; tick();
          chk("R8 clear", pend_o, 0);
        end
      end
    end
    chk("R10 sweep no lost", lost_o, 0);

    // R1 held line gives one request only
    hen_set_i = 1; tick();
    sel_i = 3'd2;
    hw_req_i[2] = 1; @(negedge clk); chk("R1 held first", pend_o, 1);
    pend_clr_i = 1; @(negedge clk); pend_clr_i = 0; chk("R1 held clr", pend_o, 0);
    @(negedge clk); chk("R1 held no retrigger", pend_o, 0);
    tick();

    // R5 software request with enable off
    hen_clr_i = 1; tick();
    sw_req_i = 1; tick(); chk("R5 sw sets", pend_o, 1);

    // R10 / R11 lost request
    sw_req_i = 1; tick();
    chk("R10 lost", lost_o, 1); chk("R10 irq", lost_irq_o, 1); chk("R10 pend", pend_o, 1);
    tick(); chk("R10 irq one cycle", lost_irq_o, 0); chk("R11 sticky", lost_o, 1);
    lost_clr_i = 1; tick(); chk("R11 w1c", lost_o, 0);
    sw_req_i = 1; lost_clr_i = 1; tick(); chk("R11 set beats w1c", lost_o, 1);
    lost_clr_i = 1; tick(); chk("R11 w1c again", lost_o, 0);

    // R9 set and clear together
    sw_req_i = 1; pend_clr_i = 1; tick();
    chk("R9 pend kept", pend_o, 1); chk("R9 not lost", lost_o, 0);
    chk("R9 no irq", lost_irq_o, 0);

    // R6 per-transfer clear
    clr_txn_i = 0;
    txn_done_i = 1; tick(); chk("R6 txn ignored", pend_o, 1);
    xfer_done_i = 1; tick(); chk("R6 xfer clears", pend_o, 0);

    // R7 per-transaction clear
    clr_txn_i = 1; sw_req_i = 1; tick(); chk("R7 set", pend_o, 1);
    xfer_done_i = 1; tick(); chk("R7 xfer ignored", pend_o, 1);
    txn_done_i = 1; tick(); chk("R7 txn clears", pend_o, 0);
    clr_txn_i = 0;

    // R4 single and continuous modes
    single_i = 1; hen_set_i = 1; tick(); chk("R4 single armed", hen_o, 1);
    txn_done_i = 1; tick(); chk("R4 single off", hen_o, 0);
    sel_i = 3'd5; hw_req_i[5] = 1; tick(); chk("R4 hw blocked", pend_o, 0);
    single_i = 0; hen_set_i = 1; tick();
    txn_done_i = 1; tick(); chk("R4 continuous kept", hen_o, 1);
    hw_req_i[5] = 1; tick(); chk("R4 hw accepted", pend_o, 1);

    // R12 suspend
    for (int k = 0; k < 4; k++) begin
      susp_en_i = k[0]; susp_glob_i = k[1];
      #1 chk("R12 suspend", susp_req_o, (k == 3));
      @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule